// File: doc/BRIEF.md
# I2C SCL Clock Divider

This block produces the timing skeleton for an I2C bit engine. A first stage divides the peripheral clock into a slower internal tick. A second stage counts those ticks to form one SCL period and marks where the low and high halves of that period begin. Software chooses the two divide factors and a small compensation count, which absorbs rise time, fall time and internal delay. The block does not work out these values from a target bus frequency.

The configuration word carries two fields. The prescale field sits in the low `PRE_W` bits, where `PRE_W` is 2 or 3. The 6-bit period step sits directly above it. The internal tick rate is the peripheral clock divided by (prescale + 1). The designer must keep that rate below 20 MHz, and the largest prescale value the field can hold sets the fastest peripheral clock the block can serve.

All pins are plain control and status pins. No data stream passes through the block, so it has no valid/ready handshake. The bit engine treats the two phase strobes as single-cycle events and can use the level output directly as its SCL drive intent.

Top module: `i2c_scl_clkdiv`

## Requirements
- R1: While `enable` is high, `tick` is a one-cycle pulse every P+1 clocks, where P = `cfg_word[PRE_W-1:0]`. With P = 0, `tick` stays high on every cycle.
- R2: The spacing between consecutive `scl_low_stb` pulses is N×(P+1) clocks, where N = 20 + 8×S + C, S = `cfg_word[PRE_W+5:PRE_W]` and C = `comp_cnt`.
- R3: The low phase lasts ceil(N/2) ticks, counted from `scl_low_stb` to `scl_high_stb`. The high phase lasts floor(N/2) ticks, so an odd N gives the extra tick to the low phase. `scl_level` is 0 in the cycle of `scl_low_stb` and 1 in the cycle of `scl_high_stb`.
- R4: `scl_low_stb` and `scl_high_stb` are never high together.
- R5: Configuration is captured on every clock edge at which `enable` is low. Changes to `cfg_word` or `comp_cnt` while `enable` is high have no effect on timing.
- R6: Counting one clock edge after `enable` is sampled low, `tick`, `scl_low_stb` and `scl_high_stb` are 0, `scl_level` is 1, and all counters restart from zero. The same holds after reset.
- R7: Take the first edge at which `enable` is sampled high as edge 1. The first `tick` appears after edge P+1, and the first `scl_low_stb` appears after edge P+2.
- R8: With `PRE_W` = 2, the period step is taken from `cfg_word[7:2]`, and R1 to R3 hold with the 2-bit prescale field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Runs the divider. While low, the divider is held and the configuration is captured |
| cfg_word | input | PRE_W+6 | Period step in bits [PRE_W+5:PRE_W], prescale in bits [PRE_W-1:0] |
| comp_cnt | input | COMP_W | Rise/fall compensation count, in ticks |
| tick | output | 1 | Internal tick enable |
| scl_low_stb | output | 1 | One-cycle pulse at the start of the SCL low phase |
| scl_high_stb | output | 1 | One-cycle pulse at the start of the SCL high phase |
| scl_level | output | 1 | Intended SCL level, 1 while idle |

## Verification
The assertions take two things for granted. First, `enable` is held low for the whole reset. Second, the period held in the shadow register is at least 20 ticks, which is always true because N cannot fall below its base. The stimulus meets both conditions: it changes every input only on the falling clock edge, and it always gives the shadow register at least one idle edge to capture a new configuration before `enable` rises. Each timing check counts cycles from the `enable` edge or between strobes. This keeps the expected values tied to P, S and C and not to absolute simulation time.

// File: rtl/i2c_clkdiv_pkg.sv
package i2c_clkdiv_pkg;
  localparam int STEP_W    = 6;
  localparam int BASE_TICKS = 20;
  localparam int STEP_MUL  = 8;

  function automatic int unsigned max_period(input int unsigned comp_w);
    return BASE_TICKS + STEP_MUL * ((1 << STEP_W) - 1) + ((1 << comp_w) - 1);
  endfunction
endpackage

// File: rtl/clkdiv_cfg_shadow.sv
module clkdiv_cfg_shadow
  import i2c_clkdiv_pkg::*;
#(
  parameter int PRE_W  = 3,
  parameter int COMP_W = 4,
  parameter int PER_W  = 10
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    enable,
  input  logic [PRE_W+STEP_W-1:0] cfg_word,
  input  logic [COMP_W-1:0]       comp_cnt,
  output logic [PRE_W-1:0]        pre_q,
  output logic [PER_W-1:0]        per_q,
  output logic [PER_W-1:0]        low_q
);
  logic [STEP_W-1:0] step;
  logic [PER_W-1:0]  per_next;
  logic [PER_W-1:0]  low_next;

  assign step     = cfg_word[PRE_W +: STEP_W];
  assign per_next = PER_W'(BASE_TICKS) + (PER_W'(step) * PER_W'(STEP_MUL)) + PER_W'(comp_cnt);
  assign low_next = (per_next + PER_W'(1)) >> 1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      per_q <= PER_W'(BASE_TICKS);
      low_q <= PER_W'(BASE_TICKS / 2);
    end else if (!enable) begin
      pre_q <= cfg_word[PRE_W-1:0];
      per_q <= per_next;
      low_q <= low_next;
    end
  end

  // R5: captured timing does not move while running
  assert_cfg_frozen_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && $past(enable)) |-> ($stable(per_q) && $stable(pre_q) && $stable(low_q)));
endmodule

// File: rtl/clkdiv_prescaler.sv
module clkdiv_prescaler #(
  parameter int PRE_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic [PRE_W-1:0] pre_q,
  output logic             tick
);
  logic [PRE_W-1:0] pcnt;
  logic             wrap;

  assign wrap = (pcnt == pre_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcnt <= '0;
      tick <= 1'b0;
    end else if (!enable) begin
      pcnt <= '0;
      tick <= 1'b0;
    end else begin
      tick <= wrap;
      pcnt <= wrap ? '0 : pcnt + PRE_W'(1);
    end
  end

  // R1: with a nonzero prescale, ticks are isolated pulses
  assert_tick_isolated_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && pre_q != '0 && enable) |=> !tick);
  // R6: idle means no ticks on the following cycle
  assert_idle_no_tick_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !tick);
endmodule

// File: rtl/clkdiv_phase_gen.sv
module clkdiv_phase_gen #(
  parameter int PER_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             tick,
  input  logic [PER_W-1:0] per_q,
  input  logic [PER_W-1:0] low_q,
  output logic             low_stb,
  output logic             high_stb,
  output logic             level
);
  logic [PER_W-1:0] tcnt;
  logic             at_start;
  logic             at_half;
  logic             at_end;

  assign at_start = (tcnt == '0);
  assign at_half  = (tcnt == low_q);
  assign at_end   = (tcnt == per_q - PER_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tcnt     <= '0;
      low_stb  <= 1'b0;
      high_stb <= 1'b0;
      level    <= 1'b1;
    end else if (!enable) begin
      tcnt     <= '0;
      low_stb  <= 1'b0;
      high_stb <= 1'b0;
      level    <= 1'b1;
    end else begin
      low_stb  <= tick && at_start;
      high_stb <= tick && at_half;
      if (tick) begin
        tcnt <= at_end ? '0 : tcnt + PER_W'(1);
        if (at_start)     level <= 1'b0;
        else if (at_half) level <= 1'b1;
      end
    end
  end

  // R2: tick counter stays inside the period
  assert_cnt_in_period_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tcnt < per_q);
  // R3: level agrees with the phase strobes
  assert_low_level_R3: assert property (@(posedge clk) disable iff (!rst_n)
    low_stb |-> !level);
  assert_high_level_R3: assert property (@(posedge clk) disable iff (!rst_n)
    high_stb |-> level);
  // R4: strobes are mutually exclusive
  assert_strobe_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({low_stb, high_stb}));
  // R6: idle clears strobes and releases the line
  assert_idle_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!low_stb && !high_stb && level));
endmodule

// File: rtl/i2c_scl_clkdiv.sv
module i2c_scl_clkdiv
  import i2c_clkdiv_pkg::*;
#(
  parameter int PRE_W  = 3,
  parameter int COMP_W = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    enable,
  input  logic [PRE_W+STEP_W-1:0] cfg_word,
  input  logic [COMP_W-1:0]       comp_cnt,
  output logic                    tick,
  output logic                    scl_low_stb,
  output logic                    scl_high_stb,
  output logic                    scl_level
);
  localparam int PER_MAX = int'(max_period(COMP_W));
  localparam int PER_W   = $clog2(PER_MAX + 2);

  logic [PRE_W-1:0] pre_q;
  logic [PER_W-1:0] per_q;
  logic [PER_W-1:0] low_q;

  clkdiv_cfg_shadow #(.PRE_W(PRE_W), .COMP_W(COMP_W), .PER_W(PER_W)) u_shadow (
    .clk(clk), .rst_n(rst_n), .enable(enable), .cfg_word(cfg_word),
    .comp_cnt(comp_cnt), .pre_q(pre_q), .per_q(per_q), .low_q(low_q)
  );

  clkdiv_prescaler #(.PRE_W(PRE_W)) u_presc (
    .clk(clk), .rst_n(rst_n), .enable(enable), .pre_q(pre_q), .tick(tick)
  );

  clkdiv_phase_gen #(.PER_W(PER_W)) u_phase (
    .clk(clk), .rst_n(rst_n), .enable(enable), .tick(tick),
    .per_q(per_q), .low_q(low_q),
    .low_stb(scl_low_stb), .high_stb(scl_high_stb), .level(scl_level)
  );
endmodule

// File: tb/i2c_scl_clkdiv_bench.sv
module i2c_scl_clkdiv_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en1 = 1'b0, en2 = 1'b0;
  logic [8:0] cfg1 = '0;
  logic [7:0] cfg2 = '0;
  logic [3:0] comp = '0;
  logic       tick1, lo1s, hi1s, lv1;
  logic       tick2, lo2s, hi2s, lv2;
  int         n_checks = 0;
  int         n_fail = 0;
  bit         done = 1'b0;

  always #5 clk = ~clk;

  i2c_scl_clkdiv u_i2c_scl_clkdiv (
    .clk(clk), .rst_n(rst_n), .enable(en1), .cfg_word(cfg1), .comp_cnt(comp),
    .tick(tick1), .scl_low_stb(lo1s), .scl_high_stb(hi1s), .scl_level(lv1)
  );

  i2c_scl_clkdiv #(.PRE_W(2)) u_i2c_scl_clkdiv_w2 (
    .clk(clk), .rst_n(rst_n), .enable(en2), .cfg_word(cfg2), .comp_cnt(comp),
    .tick(tick2), .scl_low_stb(lo2s), .scl_high_stb(hi2s), .scl_level(lv2)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic test_reset();
    chk(tick1 == 0 && lo1s == 0 && hi1s == 0, "R6 reset strobes", {tick1, lo1s, hi1s}, 0);
    chk(lv1 == 1, "R6 reset level", lv1, 1);
  endtask

  task automatic run_case(input bit w2, input int p, input int s, input int c, input string tag);
    int n, lo_ph, hi_ph, cyc, t1, t2, l1, h1, l2, lvl_lo, lvl_hi;
    logic tk, lo, hi, lv;
    n = 20 + 8 * s + c;
    lo_ph = (n + 1) / 2;
    hi_ph = n / 2;
    cyc = 0; t1 = -1; t2 = -1; l1 = -1; h1 = -1; l2 = -1; lvl_lo = -1; lvl_hi = -1;
    comp = 4'(c);
    if (w2) cfg2 = 8'((s << 2) | p); else cfg1 = 9'((s << 3) | p);
    repeat (2) @(negedge clk);
    if (w2) en2 = 1'b1; else en1 = 1'b1;
    while (l2 < 0 && cyc < 20000) begin
      @(negedge clk);
      cyc++;
      tk = w2 ? tick2 : tick1;
      lo = w2 ? lo2s : lo1s;
      hi = w2 ? hi2s : hi1s;
      lv = w2 ? lv2 : lv1;
      if (tk) begin
        if (t1 < 0) t1 = cyc;
        else if (t2 < 0) t2 = cyc;
      end
      if (lo) begin
        if (l1 < 0) begin l1 = cyc; lvl_lo = int'(lv); end
        else l2 = cyc;
      end
      if (hi && h1 < 0 && l1 >= 0) begin h1 = cyc; lvl_hi = int'(lv); end
    end
    chk(t1 == p + 1, {"R7 first tick ", tag}, t1, p + 1);
    chk(t2 - t1 == p + 1, {"R1 tick spacing ", tag}, t2 - t1, p + 1);
    chk(l1 == p + 2, {"R7 first low strobe ", tag}, l1, p + 2);
    chk(h1 - l1 == lo_ph * (p + 1), {"R3 low phase ", tag}, h1 - l1, lo_ph * (p + 1));
    chk(l2 - h1 == hi_ph * (p + 1), {"R3 high phase ", tag}, l2 - h1, hi_ph * (p + 1));
    chk(l2 - l1 == n * (p + 1), {"R2 period ", tag}, l2 - l1, n * (p + 1));
    chk(lvl_lo == 0 && lvl_hi == 1, {"R3 level ", tag}, lvl_lo * 2 + lvl_hi, 1);
    if (w2) en2 = 1'b0; else en1 = 1'b0;
    @(negedge clk);
  endtask

  task automatic test_frozen_cfg();
    int cyc, l1, l2;
    cyc = 0; l1 = -1; l2 = -1;
    cfg1 = 9'((0 << 3) | 1);
    comp = 4'd0;
    repeat (2) @(negedge clk);
    en1 = 1'b1;
    while (l2 < 0 && cyc < 5000) begin
      @(negedge clk);
      cyc++;
      if (lo1s) begin
        if (l1 < 0) begin
          l1 = cyc;
          cfg1 = 9'((40 << 3) | 6);
          comp = 4'd15;
        end else l2 = cyc;
      end
    end
    chk(l2 - l1 == 40, "R5 change while running ignored", l2 - l1, 40);
    en1 = 1'b0;
    @(negedge clk);
  endtask

  task automatic test_disable();
    int seen;
    seen = 0;
    cfg1 = 9'((1 << 3) | 2);
    comp = 4'd3;
    repeat (2) @(negedge clk);
    en1 = 1'b1;
    while (!lo1s) @(negedge clk);
    repeat (7) @(negedge clk);
    en1 = 1'b0;
    @(negedge clk);
    chk(tick1 == 0 && lo1s == 0 && hi1s == 0, "R6 outputs quiet after disable", {tick1, lo1s, hi1s}, 0);
    chk(lv1 == 1, "R6 level released", lv1, 1);
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (tick1 || lo1s || hi1s || !lv1) seen++;
    end
    chk(seen == 0, "R6 held idle", seen, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    test_reset();
    rst_n = 1'b1;
    @(negedge clk);
    run_case(1'b0, 0, 0, 0, "p0 s0 c0");
    run_case(1'b0, 3, 2, 5, "odd period");
    run_case(1'b0, 7, 63, 15, "max fields");
    run_case(1'b1, 1, 1, 1, "R8 narrow prescale");
    run_case(1'b1, 3, 5, 0, "R8 narrow prescale max");
    test_frozen_cfg();
    test_disable();
    run_case(1'b0, 2, 3, 2, "after disable");
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule